// File: doc/BRIEF.md
# Channel Trigger and Hit Capture

This block holds the trigger logic for a bank of detector channels, eight by default. For each channel it picks the event that starts the sub-channel delay. That event is either the rising edge of a global event gate, which starts every unmasked channel on the same clock, or the channel's own discriminator pulse. The block also keeps one hit flag per channel. It sets that flag from the discriminator or from a forced-acquire strobe. Each channel also gets start and stop strobes for its time measurement, which always runs from the channel's own discriminator to a shared stop.

Two control inputs pick among three ways of working:
- **Forced acquisition.** Event timing is selected and `force_hit` marks every channel.
- **Armed gated timing.** Event timing is selected and discriminator pulses that follow an arming edge of the gate mark channels.
- **Self-timed.** Discriminator timing is selected while the gate is held high.

Every input is asynchronous. Each one passes through a synchronizer of `SYNC_STAGES` flops, two by default, and then through rising-edge detection on `clk`. All strobes are registered pulses one clock wide.

The block carries no data stream, so it has no valid/ready handshake and applies no back-pressure. Every pin is a plain control or status level or strobe. A consumer that misses a strobe cannot stall the block.

Top module: `chan_trigger_capture`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low after that edge and all hit flags are cleared.
- R2: A rising input edge that is first sampled at clock edge k produces its output strobe after edge k+2. Every strobe lasts exactly one clock.
- R3: With `use_evt_timing`=1, a rising edge of `evt_gate` pulses `delay_start` for every unmasked channel in the same cycle. In this setting, discriminator pulses never pulse `delay_start`.
- R4: With `use_evt_timing`=0 and `evt_gate` high, a rising edge on `disc_pulse[i]` pulses both `delay_start[i]` and `tmeas_start[i]`, and sets `hit_flags[i]`.
- R5: While `evt_gate` is low, discriminator pulses cause no `delay_start`, no `tmeas_start` and no hit.
- R6: With `use_evt_timing`=1, a discriminator edge starts time measurement and sets the hit flag only if both of these hold:
  - a rising edge of `evt_gate` was seen on an earlier clock;
  - `evt_gate` has stayed high since that edge.

  A discriminator edge that comes before that gate edge, or on the same clock as it, produces nothing.
- R7: A rising edge of `force_hit` sets the hit flag of every unmasked channel, whatever the values of `evt_gate` and `use_evt_timing`.
- R8: `chan_mask[i]`=1 disables channel i, where bit i belongs to channel i. A disabled channel gets no `delay_start`, no `tmeas_start` and no hit setting.
- R9: `hit_flags[i]` stays set until `hit_clear[i]` is seen high. If a clear and a set reach the same channel on the same clock, the clear wins.
- R10: A rising edge of `common_stop` pulses `tmeas_stop[i]` only for channels whose time measurement has started and not yet stopped. Each started measurement is stopped once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_gate | input | 1 | Global event gate; low disables all channels |
| use_evt_timing | input | 1 | 1: the gate edge times the delay start; 0: the discriminators time it |
| force_hit | input | 1 | Rising edge sets the hit flag of all unmasked channels |
| common_stop | input | 1 | Rising edge stops all running time measurements |
| disc_pulse | input | NCH | Per-channel discriminator pulses |
| chan_mask | input | NCH | Per-channel disable, 1 = disabled |
| hit_clear | input | NCH | Per-channel hit clear, level |
| delay_start | output | NCH | One-clock delay-start strobes |
| tmeas_start | output | NCH | One-clock time-measurement start strobes |
| tmeas_stop | output | NCH | One-clock time-measurement stop strobes |
| hit_flags | output | NCH | Held hit flags |

## Verification
The assertions check the following on every cycle:
- a hit flag holds until its clear arrives;
- no start strobe appears on a channel that was masked on the previous clock;
- every measurement start leaves its hit flag set;
- a stop strobe comes only from a channel that was running;
- with event timing selected, delay starts fire on all unmasked channels together.

The order-dependent behaviour can only be shown by the bench's scenarios. That covers three things:
- whether the gate edge came before the discriminator, or on the same clock;
- the exact three-edge latency;
- a second stop that finds nothing running.

The bench's reference model replays those scenarios and compares every output on every clock.

// File: rtl/ctc_pkg.sv
`timescale 1ns/1ps
package ctc_pkg;
  // Positions of the control bits in the synchronized control word
  localparam int unsigned BIT_EVT  = 0;
  localparam int unsigned BIT_BYP  = 1;
  localparam int unsigned BIT_ACQ  = 2;
  localparam int unsigned BIT_STOP = 3;
  localparam int unsigned CTRL_W   = 4;

  // Which event times the sub-channel delay
  typedef enum logic {
    SRC_DISC  = 1'b0,
    SRC_EVENT = 1'b1
  } delay_src_e;
endpackage

// File: rtl/ctc_sync.sv
`timescale 1ns/1ps
module ctc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ctc_edge.sv
`timescale 1ns/1ps
module ctc_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/ctc_chan.sv
`timescale 1ns/1ps
module ctc_chan
  import ctc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic evt_lvl_i,
  input  logic evt_rise_i,
  input  logic byp_i,
  input  logic disc_rise_i,
  input  logic acq_rise_i,
  input  logic stop_rise_i,
  input  logic clr_i,
  output logic dly_o,
  output logic tst_o,
  output logic tsp_o,
  output logic hit_o
);
  delay_src_e src;
  logic armed_q, run_q, hit_q;
  logic gate, dly_n, tst_n, tsp_n;

  assign src = byp_i ? SRC_EVENT : SRC_DISC;

  // Timing a measurement needs an arming gate edge (event timing)
  // or a gate held high (discriminator timing).
  assign gate  = (src == SRC_EVENT) ? armed_q : 1'b1;
  assign tst_n = disc_rise_i & en_i & evt_lvl_i & gate;
  assign tsp_n = stop_rise_i & run_q;

  always_comb begin
    unique case (src)
      SRC_EVENT: dly_n = evt_rise_i & en_i;
      SRC_DISC:  dly_n = disc_rise_i & en_i & evt_lvl_i;
      default:   dly_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      hit_q   <= 1'b0;
      dly_o   <= 1'b0;
      tst_o   <= 1'b0;
      tsp_o   <= 1'b0;
    end else begin
      if (evt_rise_i)      armed_q <= en_i;
      else if (!evt_lvl_i) armed_q <= 1'b0;
      run_q <= (run_q & ~stop_rise_i) | tst_n;
      if (clr_i)                          hit_q <= 1'b0;
      else if (tst_n || (acq_rise_i && en_i)) hit_q <= 1'b1;
      dly_o <= dly_n;
      tst_o <= tst_n;
      tsp_o <= tsp_n;
    end
  end

  assign hit_o = hit_q;

  // R9
  hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_q && !clr_i) |=> hit_q);
  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    (tst_o || dly_o) |-> $past(en_i));
  // R4
  start_sets_hit_chk: assert property (@(posedge clk) disable iff (rst)
    tst_o |-> (hit_q || $past(clr_i)));
  // R10
  stop_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    tsp_o |-> $past(run_q));
  // R2
  dly_single_chk: assert property (@(posedge clk) disable iff (rst)
    dly_o |=> !dly_o);
endmodule

// File: rtl/chan_trigger_capture.sv
`timescale 1ns/1ps
module chan_trigger_capture
  import ctc_pkg::*;
#(
  parameter int unsigned NCH         = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           evt_gate,
  input  logic           use_evt_timing,
  input  logic           force_hit,
  input  logic           common_stop,
  input  logic [NCH-1:0] disc_pulse,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] hit_clear,
  output logic [NCH-1:0] delay_start,
  output logic [NCH-1:0] tmeas_start,
  output logic [NCH-1:0] tmeas_stop,
  output logic [NCH-1:0] hit_flags
);
  localparam int unsigned RAW_W  = CTRL_W + 3*NCH;
  localparam int unsigned EDGE_W = 3 + NCH;

  logic [RAW_W-1:0]  raw, syn;
  logic [CTRL_W-1:0] ctrl_s;
  logic [NCH-1:0]    disc_s, mask_s, clr_s, disc_r;
  logic [EDGE_W-1:0] edge_in, edge_r;
  logic              evt_r, acq_r, stop_r;

  assign raw = {hit_clear, chan_mask, disc_pulse,
                common_stop, force_hit, use_evt_timing, evt_gate};

  ctc_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (syn)
  );

  assign ctrl_s = syn[CTRL_W-1:0];
  assign disc_s = syn[CTRL_W +: NCH];
  assign mask_s = syn[CTRL_W+NCH +: NCH];
  assign clr_s  = syn[CTRL_W+2*NCH +: NCH];

  assign edge_in = {disc_s, ctrl_s[BIT_STOP], ctrl_s[BIT_ACQ], ctrl_s[BIT_EVT]};

  ctc_edge #(.W(EDGE_W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (edge_in),
    .rise_o (edge_r)
  );

  assign evt_r  = edge_r[0];
  assign acq_r  = edge_r[1];
  assign stop_r = edge_r[2];
  assign disc_r = edge_r[3 +: NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ctc_chan u_ch (
      .clk         (clk),
      .rst         (rst),
      .en_i        (~mask_s[c]),
      .evt_lvl_i   (ctrl_s[BIT_EVT]),
      .evt_rise_i  (evt_r),
      .byp_i       (ctrl_s[BIT_BYP]),
      .disc_rise_i (disc_r[c]),
      .acq_rise_i  (acq_r),
      .stop_rise_i (stop_r),
      .clr_i       (clr_s[c]),
      .dly_o       (delay_start[c]),
      .tst_o       (tmeas_start[c]),
      .tsp_o       (tmeas_stop[c]),
      .hit_o       (hit_flags[c])
    );
  end

  // R3
  evt_all_start_chk: assert property (@(posedge clk) disable iff (rst)
    ((|delay_start) && $past(ctrl_s[BIT_BYP])) |-> (delay_start == $past(~mask_s)));
endmodule

// File: tb/chan_trigger_capture_test.sv
`timescale 1ns/1ps
module chan_trigger_capture_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_gate = 1'b0, use_evt_timing = 1'b0, force_hit = 1'b0, common_stop = 1'b0;
  logic [N-1:0] disc_pulse = '0, chan_mask = '0, hit_clear = '0;
  logic [N-1:0] delay_start, tmeas_start, tmeas_stop, hit_flags;

  int checks = 0, fails = 0, cycles = 0;
  bit chk_on = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  chan_trigger_capture uut (
    .clk(clk), .rst(rst), .evt_gate(evt_gate), .use_evt_timing(use_evt_timing),
    .force_hit(force_hit), .common_stop(common_stop), .disc_pulse(disc_pulse),
    .chan_mask(chan_mask), .hit_clear(hit_clear), .delay_start(delay_start),
    .tmeas_start(tmeas_start), .tmeas_stop(tmeas_stop), .hit_flags(hit_flags)
  );

  // Reference model: inputs seen two edges late, edges from consecutive samples
  typedef struct packed {
    logic [N-1:0] clr, off, disc;
    logic stop, acq, byp, evt;
  } smp_t;
  smp_t h0, h1, h2, h3;
  logic [N-1:0] m_arm, m_run, e_dly, e_tst, e_tsp, e_hit;

  always @(posedge clk) begin
    logic [N-1:0] en, d_r, n_dly, n_tst, n_tsp;
    logic ev_r, ac_r, st_r;
    cycles++;
    if (rst) begin
      h0 = '0; h1 = '0; h2 = '0; h3 = '0;
      m_arm = '0; m_run = '0;
      e_dly = '0; e_tst = '0; e_tsp = '0; e_hit = '0;
      chk_on <= 1'b1;
    end else begin
      h3 = h2; h2 = h1; h1 = h0;
      h0 = {hit_clear, chan_mask, disc_pulse, common_stop, force_hit, use_evt_timing, evt_gate};
      en   = ~h2.off;
      d_r  = h2.disc & ~h3.disc;
      ev_r = h2.evt & ~h3.evt;
      ac_r = h2.acq & ~h3.acq;
      st_r = h2.stop & ~h3.stop;
      for (int c = 0; c < N; c++) begin
        n_dly[c] = h2.byp ? (ev_r & en[c]) : (d_r[c] & en[c] & h2.evt);
        n_tst[c] = d_r[c] & en[c] & h2.evt & (h2.byp ? m_arm[c] : 1'b1);
        n_tsp[c] = st_r & m_run[c];
        if (h2.clr[c]) e_hit[c] = 1'b0;
        else if (n_tst[c] || (ac_r && en[c])) e_hit[c] = 1'b1;
        m_run[c] = (m_run[c] & ~st_r) | n_tst[c];
        if (ev_r) m_arm[c] = en[c];
        else if (!h2.evt) m_arm[c] = 1'b0;
      end
      e_dly = n_dly; e_tst = n_tst; e_tsp = n_tsp;
    end
  end

  task automatic check(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", cur_req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check("delay_start", delay_start, e_dly);
      check("tmeas_start", tmeas_start, e_tst);
      check("tmeas_stop",  tmeas_stop,  e_tsp);
      check("hit_flags",   hit_flags,   e_hit);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_disc(input logic [N-1:0] m);
    @(negedge clk); disc_pulse = disc_pulse | m;
    idle(2); disc_pulse = disc_pulse & ~m;
    idle(3);
  endtask

  task automatic pulse_stop();
    @(negedge clk); common_stop = 1'b1;
    idle(2); common_stop = 1'b0;
    idle(3);
  endtask

  task automatic clear_all();
    @(negedge clk); hit_clear = '1;
    idle(3); hit_clear = '0;
    idle(3);
  endtask

  initial begin
    // R1: reset state
    idle(4);
    @(negedge clk); rst = 1'b0;
    idle(3);

    // R2 and R3: gate edge starts all unmasked channels together
    cur_req = "R3";
    use_evt_timing = 1'b1; chan_mask = 8'b0010_0000;
    idle(4);
    @(negedge clk); evt_gate = 1'b1;
    idle(6);
    // R6: armed, so a discriminator edge starts timing and sets the hit
    cur_req = "R6";
    pulse_disc(8'b0000_0100);
    @(negedge clk); evt_gate = 1'b0;
    idle(4);
    // R6: discriminator before the gate edge gives nothing
    pulse_disc(8'b0000_0010);
    @(negedge clk); evt_gate = 1'b1;
    idle(6);
    @(negedge clk); evt_gate = 1'b0;
    idle(4);
    // R6: discriminator on the same clock as the gate edge gives nothing
    @(negedge clk); evt_gate = 1'b1; disc_pulse = 8'b0000_1000;
    idle(2); disc_pulse = '0;
    idle(5);
    @(negedge clk); evt_gate = 1'b0;
    idle(4);
    // R10: stop for the running channel, then a second stop finds none
    cur_req = "R10";
    pulse_stop();
    pulse_stop();
    // R9: clear holds off
    cur_req = "R9";
    clear_all();

    // R4: self-timed mode
    cur_req = "R4";
    use_evt_timing = 1'b0; chan_mask = '0;
    @(negedge clk); evt_gate = 1'b1;
    idle(4);
    pulse_disc(8'b0000_0001);
    pulse_disc(8'b1000_1000);
    // R10: stop all three
    cur_req = "R10";
    pulse_stop();
    // R9: clear only channel 0, others held
    cur_req = "R9";
    @(negedge clk); hit_clear = 8'b0000_0001;
    idle(3); hit_clear = '0;
    idle(5);
    // R9: clear and set arriving together, clear wins
    @(negedge clk); hit_clear = 8'b0100_0000; disc_pulse = 8'b0100_0000;
    idle(3); hit_clear = '0; disc_pulse = '0;
    idle(4);

    // R8: masked channels ignore discriminators
    cur_req = "R8";
    chan_mask = 8'b0000_0110;
    idle(3);
    pulse_disc(8'b0000_0111);
    cur_req = "R9";
    clear_all();

    // R5: gate low blocks everything
    cur_req = "R5";
    @(negedge clk); evt_gate = 1'b0;
    idle(4);
    pulse_disc(8'b1111_1111);
    @(negedge clk); use_evt_timing = 1'b1;
    idle(3);
    pulse_disc(8'b0101_0101);

    // R7: forced acquire with the gate low, masked channels excluded
    cur_req = "R7";
    chan_mask = 8'b1000_0001;
    idle(3);
    @(negedge clk); force_hit = 1'b1;
    idle(2); force_hit = 1'b0;
    idle(5);
    cur_req = "R9";
    clear_all();

    // R1: reset in the middle clears hits
    cur_req = "R1";
    chan_mask = '0;
    @(negedge clk); force_hit = 1'b1;
    idle(2); force_hit = 1'b0;
    idle(5);
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    idle(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule